// File: doc/BRIEF.md
# Transmit Packet Ring Reader

This block drains a circular transmit buffer that software fills with packet records. Each record sits at a 4-byte aligned byte address. It opens with a 32-bit word that gives the payload length in bytes, and the payload bytes follow from the next word onward. The reader fetches the length word, then the payload words one at a time over a 32-bit read port with one cycle of latency. It sends the payload as a byte stream with valid/ready flow control and marks the final byte.

Software owns the write pointer. The block owns the read pointer and exposes it, so software can see how far the ring has been consumed. A length word of zero tells the reader to go back to the buffer base address. After each frame the read pointer moves to the next aligned record. A length above the configured maximum is a corrupt ring: the reader raises a sticky error and stops until reset.

Top module: `txring_reader`

## Requirements
- R1: A record begins at the aligned read pointer. Payload byte i is bits [8*(i%4)+7 : 8*(i%4)] of the word at byte address rd_ptr+4+4*(i/4), so bytes are little-endian within each word. The memory word address is the byte address shifted right by two.
- R2: A record of length L emits exactly L bytes. out_last is high on the L-th byte only, and frame_done pulses on the cycle after that byte's handshake.
- R3: When the length word reads 0x00000000, rd_ptr is reloaded from ring_base, no byte is emitted and frame_done does not pulse.
- R4: After a frame, rd_ptr becomes (rd_ptr + 4 + L) rounded up to a multiple of 4. frame_done is a single-cycle pulse in the first cycle that shows the new rd_ptr.
- R5: While rd_ptr equals wr_ptr, the block issues no memory read and out_valid stays low.
- R6: Memory bytes between the end of a payload and the next record are never emitted.
- R7: While out_valid is high and out_ready is low, out_valid, out_data and out_last hold their values. No byte is lost or repeated.
- R8: A length word greater than MAX_LEN sets len_err. len_err stays set until reset. While it is set, the block emits nothing, issues no read and freezes rd_ptr. A length equal to MAX_LEN is sent normally.
- R9: After a wrap, the empty comparison is made again against the new rd_ptr. A wrap that lands on wr_ptr leaves the block idle with no further reads.
- R10: Under reset (rst_n low at a clock edge), rd_ptr takes ring_base and out_valid, frame_done and len_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | PTR_W | Byte address of the buffer start (aligned) |
| wr_ptr | input | PTR_W | Software-owned byte address where the next record will go |
| rd_ptr | output | PTR_W | Byte address of the next record to read |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | PTR_W-2 | Word address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after mem_rd_en |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| frame_done | output | 1 | Pulse: rd_ptr advanced past a sent frame |
| len_err | output | 1 | Sticky oversized-length error |

## Verification
The handshake that moves the final byte of a frame out of the shifter is the same event that commits the pointer advance and raises the done pulse. When the sink stalls that byte, release, pointer update and done all depend on one ready edge. The bench provokes this with random ready and payload lengths that end both on and off a word boundary. It judges every accepted byte and flag against a queue built from the records, and every done pulse against the expected next pointer. A wrap marker read straight after a completed frame and a wrap that lands on the write pointer are judged by the resulting pointer and by the absence of further reads.

// File: rtl/txr_pkg.sv
// Package: shared constants and types for the transmit ring reader.
// Assumes 32-bit memory words carrying four 8-bit bytes.
package txr_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int BPW    = WORD_W / BYTE_W;
    localparam int CNT_W  = $clog2(BPW + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN,
        ST_FETCH,
        ST_WAIT,
        ST_SEND,
        ST_HALT
    } rd_state_e;
endpackage

// File: rtl/txr_unpack.sv
// Module: txr_unpack
// Holds one payload word and presents it byte by byte, lowest byte first.
// Assumes a load only arrives while the holder is empty.
module txr_unpack
    import txr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld,
    input  logic [WORD_W-1:0]    ld_word,
    input  logic [CNT_W-1:0]     ld_cnt,
    input  logic                 ld_last,
    input  logic                 out_ready,
    output logic                 out_valid,
    output logic [BYTE_W-1:0]    out_data,
    output logic                 out_last,
    output logic                 drained
);
    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_q;
    logic              fire;

    // Output view of the holder
    always_comb begin
        out_valid = (cnt_q != '0);
        out_data  = word_q[BYTE_W-1:0];
        out_last  = last_q && (cnt_q == CNT_W'(1));
        fire      = out_valid && out_ready;
        drained   = fire && (cnt_q == CNT_W'(1));
    end

    // Load a word or shift out one byte per handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
        end else if (ld) begin
            word_q <= ld_word;
            cnt_q  <= ld_cnt;
            last_q <= ld_last;
        end else if (fire) begin
            word_q <= word_q >> BYTE_W;
            cnt_q  <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/txr_fetch.sv
// Module: txr_fetch
// Walks the ring record by record: reads the length word, handles wrap
// markers and oversized lengths, fetches payload words and advances the
// read pointer. Assumes ring_base and wr_ptr are 4-byte aligned.
module txr_fetch
    import txr_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int MAX_LEN = 1518,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int AW     = PTR_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PTR_W-1:0]     ring_base,
    input  logic [PTR_W-1:0]     wr_ptr,
    input  logic [WORD_W-1:0]    mem_rd_data,
    input  logic                 drained,
    output logic                 mem_rd_en,
    output logic [AW-1:0]        mem_rd_addr,
    output logic [PTR_W-1:0]     rd_ptr,
    output logic                 ld,
    output logic [WORD_W-1:0]    ld_word,
    output logic [CNT_W-1:0]     ld_cnt,
    output logic                 ld_last,
    output logic                 frame_done,
    output logic                 len_err
);
    rd_state_e          state_q;
    logic [PTR_W-1:0]   rd_ptr_q;
    logic [PTR_W-1:0]   fetch_ptr_q;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   rem_q;
    logic               done_q;
    logic               err_q;
    logic               pending;
    logic [PTR_W-1:0]   next_ptr;

    // Pending-record test and next aligned record address
    always_comb begin
        pending  = (rd_ptr_q != wr_ptr);
        next_ptr = (rd_ptr_q + PTR_W'(4) + PTR_W'(len_q) + PTR_W'(3)) & ~PTR_W'(3);
    end

    // Memory request and holder load controls
    always_comb begin
        mem_rd_en   = ((state_q == ST_IDLE) && pending) || (state_q == ST_FETCH);
        mem_rd_addr = (state_q == ST_FETCH) ? fetch_ptr_q[PTR_W-1:2] : rd_ptr_q[PTR_W-1:2];
        ld          = (state_q == ST_WAIT);
        ld_word     = mem_rd_data;
        ld_cnt      = (rem_q >= LEN_W'(BPW)) ? CNT_W'(BPW) : CNT_W'(rem_q);
        ld_last     = (rem_q <= LEN_W'(BPW));
    end

    // Record walk state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rd_ptr_q    <= ring_base;
            fetch_ptr_q <= '0;
            len_q       <= '0;
            rem_q       <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (pending) state_q <= ST_LEN;
                end
                ST_LEN: begin
                    if (mem_rd_data == '0) begin
                        rd_ptr_q <= ring_base;
                        state_q  <= ST_IDLE;
                    end else if (mem_rd_data > WORD_W'(MAX_LEN)) begin
                        err_q   <= 1'b1;
                        state_q <= ST_HALT;
                    end else begin
                        len_q       <= mem_rd_data[LEN_W-1:0];
                        rem_q       <= mem_rd_data[LEN_W-1:0];
                        fetch_ptr_q <= rd_ptr_q + PTR_W'(4);
                        state_q     <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    rem_q       <= rem_q - LEN_W'(ld_cnt);
                    fetch_ptr_q <= fetch_ptr_q + PTR_W'(4);
                    state_q     <= ST_SEND;
                end
                ST_SEND: begin
                    if (drained) begin
                        if (rem_q == '0) begin
                            rd_ptr_q <= next_ptr;
                            done_q   <= 1'b1;
                            state_q  <= ST_IDLE;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    assign rd_ptr     = rd_ptr_q;
    assign frame_done = done_q;
    assign len_err    = err_q;
endmodule

// File: rtl/txring_reader.sv
// Module: txring_reader
// Top of the transmit ring reader: joins the record walker to the byte
// holder. Assumes software keeps records aligned, writes a zero length
// word before restarting at ring_base, and never overruns unread records.
module txring_reader
    import txr_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int MAX_LEN = 1518,
    localparam int AW     = PTR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ring_base,
    input  logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              frame_done,
    output logic              len_err
);
    logic              ld;
    logic [WORD_W-1:0] ld_word;
    logic [CNT_W-1:0]  ld_cnt;
    logic              ld_last;
    logic              drained;

    txr_fetch #(
        .PTR_W   (PTR_W),
        .MAX_LEN (MAX_LEN)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_base   (ring_base),
        .wr_ptr      (wr_ptr),
        .mem_rd_data (mem_rd_data),
        .drained     (drained),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .rd_ptr      (rd_ptr),
        .ld          (ld),
        .ld_word     (ld_word),
        .ld_cnt      (ld_cnt),
        .ld_last     (ld_last),
        .frame_done  (frame_done),
        .len_err     (len_err)
    );

    txr_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld),
        .ld_word   (ld_word),
        .ld_cnt    (ld_cnt),
        .ld_last   (ld_last),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last),
        .drained   (drained)
    );
endmodule

// File: rtl/txr_checker.sv
// Module: txr_checker
// Protocol and pointer properties of the ring reader, attached by bind.
module txr_checker #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PTR_W-1:0] rd_ptr,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             frame_done,
    input logic             len_err,
    input logic             mem_rd_en
);
    // Stalled byte holds (R7)
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // Done is a single-cycle pulse (R4)
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // Accepted final byte is followed by done (R2)
    p_last_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> frame_done);

    // Error flag is sticky (R8)
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err);

    // Halted reader is silent and frozen (R8)
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |-> (!out_valid && !mem_rd_en && !frame_done));

    p_err_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_err && $past(len_err)) |-> $stable(rd_ptr));

    // Read pointer stays aligned (R1)
    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr[1:0] == 2'b00);
endmodule

bind txring_reader txr_checker #(.PTR_W(PTR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ptr     (rd_ptr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .frame_done (frame_done),
    .len_err    (len_err),
    .mem_rd_en  (mem_rd_en)
);

// File: tb/tb_txring_reader.sv
module tb_txring_reader;
    localparam int PTR_W   = 10;
    localparam int MAX_LEN = 64;
    localparam logic [PTR_W-1:0] BASE = 10'h040;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PTR_W-1:0]  wr_ptr = BASE;
    logic [PTR_W-1:0]  rd_ptr;
    logic              mem_rd_en;
    logic [PTR_W-3:0]  mem_rd_addr;
    logic [31:0]       mem_rd_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [7:0]        out_data;
    logic              out_last;
    logic              frame_done;
    logic              len_err;

    always #10 clk = ~clk;

    txring_reader #(.PTR_W(PTR_W), .MAX_LEN(MAX_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE), .wr_ptr(wr_ptr),
        .rd_ptr(rd_ptr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .frame_done(frame_done),
        .len_err(len_err)
    );

    // Memory with one cycle of read latency
    logic [31:0] mem [0:255];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

    int checks = 0, fails = 0, cyc = 0, done_cnt = 0, frames = 0, reads = 0;
    bit bp_en = 0;
    bit prev_stall = 0;
    logic [7:0] prev_data;
    logic       prev_last;
    logic [7:0] exp_q[$];
    bit         last_q[$];
    logic [PTR_W-1:0] ptr_q[$];
    logic [PTR_W-1:0] sw;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [PTR_W-1:0] alignup(input int a);
        return PTR_W'((a + 3) & ~3);
    endfunction

    // Software side: place one record, fill padding with 0xA5 (R6)
    task automatic put_frame(input int len, input int seed);
        logic [7:0] b;
        mem[sw[PTR_W-1:2]] = 32'(len);
        for (int w = 0; w < (len + 3) / 4; w++) mem[sw[PTR_W-1:2] + w + 1] = 32'hA5A5A5A5;
        for (int i = 0; i < len; i++) begin
            b = 8'((seed + i * 7) & 8'hff);
            mem[sw[PTR_W-1:2] + i / 4 + 1][8 * (i % 4) +: 8] = b;
            exp_q.push_back(b);
            last_q.push_back(i == len - 1);
        end
        sw = alignup(sw + 4 + len);
        ptr_q.push_back(sw);
        frames++;
    endtask

    task automatic put_wrap();
        mem[sw[PTR_W-1:2]] = 32'h0;
        sw = BASE;
    endtask

    task automatic publish();
        @(posedge clk); #1 wr_ptr = sw;
    endtask

    task automatic drain();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && rd_ptr == wr_ptr && !out_valid) break;
        end
        repeat (5) @(negedge clk);
    endtask

    // Sink backpressure
    always @(posedge clk) begin
        #1 out_ready = bp_en ? ($urandom_range(2) != 0) : 1'b1;
    end

    // Per-clock comparison against the queued reference
    always @(negedge clk) begin
        logic [7:0] e;
        bit l;
        logic [PTR_W-1:0] p;
        cyc++;
        if (rst_n) begin
            if (mem_rd_en) reads++;
            if (prev_stall)
                chk(out_valid && out_data == prev_data && out_last == prev_last,
                    "R7 hold", int'(out_data), int'(prev_data));
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R5/R6 unexpected byte", int'(out_data), 0);
                end else begin
                    e = exp_q.pop_front();
                    l = last_q.pop_front();
                    chk(out_data == e, "R1 data", int'(out_data), int'(e));
                    chk(out_last == l, "R2 last", int'(out_last), int'(l));
                end
            end
            if (frame_done) begin
                done_cnt++;
                if (ptr_q.size() == 0) begin
                    chk(0, "R3 extra done", int'(rd_ptr), 0);
                end else begin
                    p = ptr_q.pop_front();
                    chk(rd_ptr == p, "R4 next ptr", int'(rd_ptr), int'(p));
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
        end else begin
            prev_stall = 0;
        end
        if (cyc > 100000) begin
            chk(0, "watchdog", cyc, 100000);
            summary();
        end
    end

    initial begin
        int r0;
        for (int i = 0; i < 256; i++) mem[i] = 32'hDEADBEEF;
        sw = BASE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(rd_ptr == BASE, "R10 rd_ptr", int'(rd_ptr), int'(BASE));
        chk(!out_valid && !frame_done && !len_err, "R10 outputs", int'(out_valid), 0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R5: empty ring stays idle
        repeat (20) @(negedge clk);
        chk(reads == 0, "R5 no reads", reads, 0);

        // R1 R2 R4 R6: mixed lengths, free-flowing sink
        put_frame(1, 8'h10); put_frame(4, 8'h20); put_frame(5, 8'h30);
        put_frame(7, 8'h40); put_frame(8, 8'h50); put_frame(13, 8'h60);
        publish(); drain();
        chk(done_cnt == frames, "R4 done count", done_cnt, frames);
        chk(rd_ptr == sw, "R4 final ptr", int'(rd_ptr), int'(sw));

        // R7 under backpressure; R8 boundary: MAX_LEN itself is sent
        bp_en = 1;
        put_frame(MAX_LEN, 8'h70); put_frame(3, 8'h80); put_frame(2, 8'h90); put_frame(9, 8'hA0);
        publish(); drain();
        chk(done_cnt == frames, "R8 max length sent", done_cnt, frames);
        chk(rd_ptr == sw, "R7 ptr after stalls", int'(rd_ptr), int'(sw));

        // R3: zero marker wraps to base, no done for it
        put_wrap(); put_frame(6, 8'hB0);
        publish(); drain();
        chk(done_cnt == frames, "R3 no done on wrap", done_cnt, frames);
        chk(rd_ptr == sw, "R3 ptr after wrap", int'(rd_ptr), int'(sw));

        // R9: wrap onto the write pointer leaves the block idle
        put_wrap(); publish();
        repeat (10) @(negedge clk);
        chk(rd_ptr == BASE, "R9 wrapped ptr", int'(rd_ptr), int'(BASE));
        r0 = reads;
        repeat (20) @(negedge clk);
        chk(reads == r0, "R9 idle after wrap", reads, r0);

        // R8: oversized length halts
        mem[BASE[PTR_W-1:2]] = 32'(MAX_LEN + 1);
        @(posedge clk); #1 wr_ptr = alignup(BASE + 4 + MAX_LEN + 1);
        repeat (30) @(negedge clk);
        chk(len_err == 1'b1, "R8 err set", int'(len_err), 1);
        chk(rd_ptr == BASE, "R8 ptr frozen", int'(rd_ptr), int'(BASE));
        r0 = reads;
        repeat (20) @(negedge clk);
        chk(reads == r0 && len_err, "R8 halted", reads, r0);

        // R10: reset clears the error and reloads the pointer
        @(posedge clk); #1 rst_n = 1'b0; wr_ptr = BASE;
        repeat (2) @(negedge clk);
        chk(!len_err, "R10 err cleared", int'(len_err), 0);
        chk(rd_ptr == BASE, "R10 ptr reload", int'(rd_ptr), int'(BASE));
        @(posedge clk); #1 rst_n = 1'b1;

        // Recovery after reset
        sw = BASE;
        put_frame(5, 8'hC0);
        publish(); drain();
        chk(done_cnt == frames, "R2 done after reset", done_cnt, frames);
        chk(exp_q.size() == 0, "R2 all bytes out", exp_q.size(), 0);
        summary();
    end
endmodule